// File: doc/BRIEF.md
# Guard-Block Address Watchpoint

This block watches a processor's data-bus access stream and raises a debug event when an access lands inside a guard block of memory. The guard block is set by a stored compare address and a mask count. The mask count tells the comparator how many low address bits to ignore. One comparator can therefore cover a whole aligned power-of-two region, for example a 256-byte strip placed just below the lowest legal stack address. The first push that crosses the stack limit then trips the watchpoint.

A match is turned into one of two single-cycle requests. If debug halting is enabled, the block raises a halt request. If halting is off and monitor mode is on, it raises a monitor exception request instead. If both are off, no request is raised, but a sticky match flag is still set. Software clears that flag by reading the status. A simple register-write port sets the compare address, the mask count, an access-direction function and the two routing controls.

Top module: `wp_guard_watch`

## Requirements
- R1: After reset, `halt_req`, `mon_req` and `matched` are 0, and the function is disabled, so no access matches until the function is programmed.
- R2: An access hits when `bus_valid` is 1, the direction is allowed, and the address equals the compare address with the low `mask` bits of both ignored. The low `mask` bits of the stored compare address have no effect. A cycle with `bus_valid` low never causes a request.
- R3: The mask count is 5 bits, taken from `cfg_wdata[4:0]`, and every value is honoured. A count of 0 is an exact match. A count at or above the address width matches every address.
- R4: The function field is taken from `cfg_wdata[1:0]`. Code 0 means disabled, 1 means reads only (`bus_write`=0), 2 means writes only (`bus_write`=1) and 3 means both.
- R5: When the halt-enable control is 1, a hit raises `halt_req` in the cycle after the access, whatever the monitor-enable control is, and `mon_req` stays 0.
- R6: When halt-enable is 0 and monitor-enable is 1, a hit raises `mon_req` in the cycle after the access, and `halt_req` stays 0.
- R7: When both controls are 0, a hit raises neither request but still sets `matched`.
- R8: `matched` goes to 1 in the cycle after a hit and stays 1. A cycle with `sta_rd`=1 clears it for the next cycle, unless that same cycle also hits, in which case it stays 1.
- R9: Register writes are selected by `cfg_sel`: 0 is the compare address, 1 the mask count, 2 the function, 3 the controls (`cfg_wdata[0]` halt-enable, `cfg_wdata[1]` monitor-enable). A write takes effect from the next cycle. An access in the same cycle as a write is checked against the old settings.
- R10: Each request is a one-cycle pulse per hitting access. A lone hit gives exactly one high cycle, and hits on consecutive cycles give a request on each following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | ADDR_W | Register write data |
| sta_rd | input | 1 | Status read strobe, clears the match flag |
| bus_valid | input | 1 | Bus access valid |
| bus_addr | input | ADDR_W | Bus access address |
| bus_write | input | 1 | Bus access is a write |
| halt_req | output | 1 | Halt request pulse |
| mon_req | output | 1 | Monitor exception request pulse |
| matched | output | 1 | Sticky match flag |

## Verification
The bench builds the block with a 16-bit address and the full 5-bit mask count. Mask counts of 16 through 31 therefore all reach the match-everything case, next to narrow masks such as 8 and the exact-match count of 0. A narrow address also makes the block edges, such as 0x12FF against 0x1300, easy to place. Reconfiguration in the same cycle as an access is driven on purpose to expose the old-settings rule.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    FN_OFF = 2'd0,
    FN_RD  = 2'd1,
    FN_WR  = 2'd2,
    FN_RW  = 2'd3
  } wp_fn_e;

  typedef enum logic [1:0] {
    SEL_COMP = 2'd0,
    SEL_MASK = 2'd1,
    SEL_FUNC = 2'd2,
    SEL_CTRL = 2'd3
  } wp_sel_e;

  typedef struct packed {
    logic mon_en;
    logic halt_en;
  } wp_ctrl_t;
endpackage

// File: rtl/wp_cfg_regs.sv
module wp_cfg_regs
  import wp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MASK_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] comp,
  output logic [MASK_W-1:0] mask,
  output wp_fn_e            fn,
  output wp_ctrl_t          ctrl
);
  logic [ADDR_W-1:0] comp_d;
  logic [MASK_W-1:0] mask_d;
  wp_fn_e            fn_d;
  wp_ctrl_t          ctrl_d;

  always_comb begin
    comp_d = comp;
    mask_d = mask;
    fn_d   = fn;
    ctrl_d = ctrl;
    if (we) begin
      case (wp_sel_e'(sel))
        SEL_COMP: comp_d = wdata;
        SEL_MASK: mask_d = wdata[MASK_W-1:0];
        SEL_FUNC: fn_d   = wp_fn_e'(wdata[1:0]);
        SEL_CTRL: ctrl_d = '{mon_en: wdata[1], halt_en: wdata[0]};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comp <= '0;
      mask <= '0;
      fn   <= FN_OFF;
      ctrl <= '0;
    end else begin
      comp <= comp_d;
      mask <= mask_d;
      fn   <= fn_d;
      ctrl <= ctrl_d;
    end
  end
endmodule

// File: rtl/wp_addr_match.sv
module wp_addr_match
  import wp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MASK_W = 5
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] comp,
  input  logic [MASK_W-1:0] mask,
  input  wp_fn_e            fn,
  output logic              hit
);
  logic [ADDR_W-1:0] keep;
  logic              dir_ok;
  logic              addr_eq;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_keep
    assign keep[i] = (32'(i) >= 32'(mask));
  end

  always_comb begin
    unique case (fn)
      FN_RD:   dir_ok = !write;
      FN_WR:   dir_ok = write;
      FN_RW:   dir_ok = 1'b1;
      default: dir_ok = 1'b0;
    endcase
    addr_eq = ((addr ^ comp) & keep) == '0;
    hit     = valid && dir_ok && addr_eq;
  end
endmodule

// File: rtl/wp_event_route.sv
module wp_event_route
  import wp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hit,
  input  wp_ctrl_t ctrl,
  input  logic     sta_rd,
  output logic     halt_req,
  output logic     mon_req,
  output logic     matched
);
  logic halt_d, mon_d, matched_d;

  always_comb begin
    halt_d    = hit && ctrl.halt_en;
    mon_d     = hit && !ctrl.halt_en && ctrl.mon_en;
    matched_d = hit || (matched && !sta_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_req <= 1'b0;
      mon_req  <= 1'b0;
      matched  <= 1'b0;
    end else begin
      halt_req <= halt_d;
      mon_req  <= mon_d;
      matched  <= matched_d;
    end
  end

  assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_req && mon_req));
  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.halt_en && !ctrl.mon_en) |=> (!halt_req && !mon_req));
  assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> matched);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (matched && !sta_rd) |=> matched);
endmodule

// File: rtl/wp_guard_watch.sv
module wp_guard_watch
  import wp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MASK_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              sta_rd,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_write,
  output logic              halt_req,
  output logic              mon_req,
  output logic              matched
);
  logic              rst_q1, rst_q2;
  logic [ADDR_W-1:0] comp;
  logic [MASK_W-1:0] mask;
  wp_fn_e            fn;
  wp_ctrl_t          ctrl;
  logic              hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  wp_cfg_regs #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_regs (
    .clk(clk), .rst_n(rst_q2), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .comp(comp), .mask(mask), .fn(fn), .ctrl(ctrl)
  );

  wp_addr_match #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_match (
    .valid(bus_valid), .write(bus_write), .addr(bus_addr),
    .comp(comp), .mask(mask), .fn(fn), .hit(hit)
  );

  wp_event_route u_route (
    .clk(clk), .rst_n(rst_q2), .hit(hit), .ctrl(ctrl), .sta_rd(sta_rd),
    .halt_req(halt_req), .mon_req(mon_req), .matched(matched)
  );

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> (!halt_req && !mon_req));
  assert_off_R4: assert property (@(posedge clk) disable iff (!rst_q2)
    (fn == FN_OFF) |=> (!halt_req && !mon_req));
endmodule

// File: tb/wp_guard_watch_bench.sv
module wp_guard_watch_bench;
  localparam int AW = 16;
  localparam int MW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          sta_rd = 1'b0;
  logic          bus_valid = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_write = 1'b0;
  logic          halt_req, mon_req, matched;

  always #5 clk = ~clk;

  wp_guard_watch #(.ADDR_W(AW), .MASK_W(MW)) u_wp_guard_watch (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .sta_rd(sta_rd), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_write(bus_write),
    .halt_req(halt_req), .mon_req(mon_req), .matched(matched)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit check_on = 1'b0;
  string ph = "R1";

  // behavioural reference
  logic [31:0] m_comp;
  int          m_mask;
  int          m_fn;
  bit          m_halt, m_mon;
  bit          e_halt, e_mon, e_match;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_comp = 0; m_mask = 0; m_fn = 0; m_halt = 0; m_mon = 0;
      e_halt = 0; e_mon = 0; e_match = 0;
    end else begin
      bit hit;
      bit dir;
      logic [31:0] a;
      a   = 32'(bus_addr);
      dir = (m_fn == 3) || (m_fn == 1 && !bus_write) || (m_fn == 2 && bus_write);
      hit = bus_valid && dir && ((a >> m_mask) == (m_comp >> m_mask));
      e_halt  = hit && m_halt;
      e_mon   = hit && !m_halt && m_mon;
      e_match = hit ? 1'b1 : (sta_rd ? 1'b0 : e_match);
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: m_comp = 32'(cfg_wdata);
          2'd1: m_mask = int'(cfg_wdata[MW-1:0]);
          2'd2: m_fn   = int'(cfg_wdata[1:0]);
          default: begin m_halt = cfg_wdata[0]; m_mon = cfg_wdata[1]; end
        endcase
      end
    end
  end

  task automatic cmp(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at cycle %0d", ph, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (check_on) begin
      cmp("halt_req", halt_req, e_halt);
      cmp("mon_req", mon_req, e_mon);
      cmp("matched", matched, e_match);
    end
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(bit v, logic [AW-1:0] a, bit w,
                      bit we = 0, logic [1:0] s = 0, logic [AW-1:0] d = 0, bit rd = 0);
    @(negedge clk);
    bus_valid = v; bus_addr = a; bus_write = w;
    cfg_we = we; cfg_sel = s; cfg_wdata = d; sta_rd = rd;
  endtask

  task automatic wr(logic [1:0] s, logic [AW-1:0] d);
    step(0, 0, 0, 1, s, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_on = 1'b1;

    ph = "R1";
    idle(2);
    step(1, 16'h0000, 1);
    step(1, 16'h0000, 0);
    idle(2);

    ph = "R9";
    step(1, 16'h0000, 1, 1, 2'd2, 16'd3);   // same-cycle: old (disabled)
    step(1, 16'h0000, 1);                    // now hits
    idle(2);

    ph = "R7";
    step(1, 16'h0000, 0);
    idle(2);

    ph = "R8";
    step(0, 0, 0, 0, 0, 0, 1);
    idle(2);
    step(1, 16'h0000, 1);
    step(1, 16'h0000, 1, 0, 0, 0, 1);
    idle(1);
    step(0, 0, 0, 0, 0, 0, 1);
    idle(1);

    ph = "R5";
    wr(2'd3, 16'd3);
    step(1, 16'h0000, 1);
    idle(2);
    wr(2'd3, 16'd1);
    step(1, 16'h0000, 0);
    idle(2);

    ph = "R6";
    wr(2'd3, 16'd2);
    step(1, 16'h0000, 1);
    idle(2);

    ph = "R2";
    wr(2'd0, 16'h1234);
    wr(2'd1, 16'd8);
    step(1, 16'h12FF, 1);
    step(1, 16'h1300, 1);
    step(1, 16'h1200, 0);
    step(1, 16'h11FF, 1);
    step(0, 16'h1200, 1);
    idle(1);
    wr(2'd1, 16'd0);
    step(1, 16'h1234, 1);
    step(1, 16'h1235, 1);
    idle(1);

    ph = "R3";
    wr(2'd1, 16'd31);
    step(1, 16'hFFFF, 1);
    step(1, 16'h0001, 0);
    wr(2'd1, 16'd16);
    step(1, 16'h8000, 1);
    wr(2'd1, 16'd15);
    step(1, 16'h8000, 1);
    step(1, 16'h0000, 1);
    idle(1);

    ph = "R4";
    wr(2'd1, 16'd4);
    wr(2'd2, 16'd1);
    step(1, 16'h123F, 1);
    step(1, 16'h123F, 0);
    wr(2'd2, 16'd2);
    step(1, 16'h1230, 0);
    step(1, 16'h1230, 1);
    wr(2'd2, 16'd0);
    step(1, 16'h1230, 1);
    step(1, 16'h1230, 0);
    idle(1);

    ph = "R10";
    wr(2'd2, 16'd3);
    wr(2'd3, 16'd1);
    step(1, 16'h1231, 1);
    idle(3);
    step(1, 16'h1231, 1);
    step(1, 16'h1232, 0);
    step(1, 16'h1233, 1);
    idle(3);

    check_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule